// File: doc/BRIEF.md
# Dual-Rail Soft-Start Sequencer

This block brings up a positive and a negative supply rail in a controlled order. When the enable input rises and the switches-off control is low, it first counts a fixed configuration delay. It then starts the two soft-start references in the order picked by a 2-bit sequence code: no rail, negative then positive, positive then negative, or both together. Each reference is a digital accumulator that climbs by a power-of-two step every clock cycle and stops at full scale. In the two ordered modes, the second rail waits for the first rail's "near regulation" flag.

The block drives one power-switch enable per rail. It also drives two controls for the positive rail's series disconnect switch: one that is asserted while the rail is ramping, and one that turns it fully on once the positive rail reports regulation. Pulling enable low or raising switches-off drops everything at once. Releasing the halt runs the full start-up again from zero. A power-down discharge request is passed on only when enable is low and the simultaneous-start code is selected.

Top module: `pwrseq_top`

## Requirements
- R1: After the block leaves its halted state, both switch enables and both ramp outputs stay 0 for exactly DELAY_CYC clock cycles. The first switch enable appears in the next cycle.
- R2: The sequence code is taken at the end of the delay. 2'b00 keeps both rails off, 2'b01 starts the negative rail alone, 2'b10 starts the positive rail alone, and 2'b11 starts both rails in the same cycle.
- R3: In an ordered mode, the second rail's switch enable rises one cycle after the first rail's near flag is high at a clock edge. The first rail is the negative rail for 2'b01 and the positive rail for 2'b10. The second rail's own near flag has no effect during that phase.
- R4: A running rail's ramp output is 0 in the first cycle its switch is on. After that it rises by 2**ramp_code (1, 2, 4 or 8) every cycle.
- R5: A ramp output saturates at 2**RAMP_W-1 and holds that value.
- R6: In any cycle where switches-off is 1 or enable is 0, both ramps read 0, both switch enables are 0 and both disconnect controls are 0. The block returns to its halted state at the next edge.
- R7: Releasing the halt restarts the whole sequence, including the full delay, with both ramps starting again from 0.
- R8: disc_drive equals the positive rail's switch enable. disc_full is 1 only while the positive rail is switched on and near_pos is 1.
- R9: pd_dis_en is 1 exactly when enable is 0, pd_opt is 1 and the sequence code is 2'b11.
- R10: After reset, with enable low, every output except pd_dis_en reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Block enable |
| sw_off | input | 1 | Switches-off request (halt) |
| seq_code | input | 2 | Start-order code |
| ramp_code | input | 2 | Ramp step exponent |
| near_pos | input | 1 | Positive rail near regulation |
| near_neg | input | 1 | Negative rail near regulation |
| pd_opt | input | 1 | Power-down discharge option |
| ramp_pos | output | RAMP_W | Positive rail soft-start reference |
| ramp_neg | output | RAMP_W | Negative rail soft-start reference |
| sw_pos_en | output | 1 | Positive rail power switch enable |
| sw_neg_en | output | 1 | Negative rail power switch enable |
| disc_drive | output | 1 | Disconnect switch driven (ramping) |
| disc_full | output | 1 | Disconnect switch fully on |
| pd_dis_en | output | 1 | Power-down discharge active |

## Verification
The halt gating, the disconnect controls and the discharge output are combinational, so they are checked one clock after the stimulus is applied. A switch enable rises on the edge that ends the delay, which is edge DELAY_CYC+1 counted from the enabling edge. Each ramp's first nonzero value appears one edge after its switch rises. The bench applies inputs on the falling edge and counts falling edges, so every check lands at an exact count of rising edges. It computes the expected ramp value as the step times the number of edges past the switch-on edge, capped at full scale.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_WAIT  = 3'd1,
    ST_FIRST = 3'd2,
    ST_BOTH  = 3'd3,
    ST_PARK  = 3'd4
  } seq_state_e;

  localparam logic [1:0] SEQ_NONE = 2'b00;
  localparam logic [1:0] SEQ_NEG1 = 2'b01;
  localparam logic [1:0] SEQ_POS1 = 2'b10;
  localparam logic [1:0] SEQ_BOTH = 2'b11;

  // Step size for a ramp code: 1, 2, 4 or 8.
  function automatic logic [3:0] ramp_step(input logic [1:0] code);
    return 4'd1 << code;
  endfunction

  // Saturating accumulate, capped at full.
  function automatic logic [31:0] ramp_sat_add(input logic [31:0] acc,
                                               input logic [1:0]  code,
                                               input logic [31:0] full);
    logic [32:0] sum;
    sum = {1'b0, acc} + {29'd0, ramp_step(code)};
    if (sum > {1'b0, full}) return full;
    return sum[31:0];
  endfunction

endpackage

// File: rtl/pwrseq_delay.sv
module pwrseq_delay #(
  parameter int DELAY_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic done
);
  localparam int CW = (DELAY_CYC < 2) ? 1 : $clog2(DELAY_CYC);
  localparam logic [CW-1:0] LAST = CW'(DELAY_CYC - 1);

  logic [CW-1:0] cnt_q;

  assign done = run && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt_q <= '0;
    else if (!run)      cnt_q <= '0;
    else if (!done)     cnt_q <= cnt_q + 1'b1;
  end

  // R1: the count never runs past its last value
  p_cnt_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

  // R1: the count starts at zero each time the delay is entered
  p_cnt_restart_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> cnt_q == '0);

endmodule

// File: rtl/pwrseq_ramp.sv
module pwrseq_ramp #(
  parameter int RAMP_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [1:0]        code,
  output logic [RAMP_W-1:0] ramp
);
  import pwrseq_pkg::*;

  localparam logic [RAMP_W-1:0] FULL = {RAMP_W{1'b1}};

  logic [RAMP_W-1:0] acc_q;
  logic              at_full;

  assign at_full = (acc_q == FULL);
  assign ramp    = go ? acc_q : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   acc_q <= '0;
    else if (!go) acc_q <= '0;
    else          acc_q <= RAMP_W'(ramp_sat_add(32'(acc_q), code, 32'(FULL)));
  end

  // R4: while running, the reference never falls
  p_monotone_r4: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> acc_q >= $past(acc_q));

  // R5: full scale is held while the rail keeps running
  p_hold_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (go && at_full) |=> acc_q == FULL);

  // R6: a stopped rail restarts from zero
  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !go |=> acc_q == '0);

endmodule

// File: rtl/pwrseq_fsm.sv
module pwrseq_fsm (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    halt,
  input  logic [1:0]              seq_code,
  input  logic                    near_pos,
  input  logic                    near_neg,
  input  logic                    dly_done,
  output pwrseq_pkg::seq_state_e  state,
  output logic                    dly_run,
  output logic                    go_pos,
  output logic                    go_neg
);
  import pwrseq_pkg::*;

  seq_state_e state_q, state_d;
  logic [1:0] order_q;
  logic       first_near;
  logic       first_is_pos;
  logic       delay_end;

  assign state        = state_q;
  assign dly_run      = (state_q == ST_WAIT) && !halt;
  assign delay_end    = dly_run && dly_done;
  assign first_is_pos = (order_q == SEQ_POS1);
  assign first_near   = first_is_pos ? near_pos : near_neg;

  always_comb begin
    state_d = state_q;
    if (halt) begin
      state_d = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE:  state_d = ST_WAIT;
        ST_WAIT: begin
          if (dly_done) begin
            unique case (seq_code)
              SEQ_NONE: state_d = ST_PARK;
              SEQ_BOTH: state_d = ST_BOTH;
              default:  state_d = ST_FIRST;
            endcase
          end
        end
        ST_FIRST: if (first_near) state_d = ST_BOTH;
        ST_BOTH:  state_d = ST_BOTH;
        ST_PARK:  state_d = ST_PARK;
        default:  state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      order_q <= SEQ_NONE;
    end else begin
      state_q <= state_d;
      if (delay_end) order_q <= seq_code;
    end
  end

  assign go_pos = !halt && ((state_q == ST_BOTH) || ((state_q == ST_FIRST) && first_is_pos));
  assign go_neg = !halt && ((state_q == ST_BOTH) || ((state_q == ST_FIRST) && !first_is_pos));

  // R1: no ramp state is reached before the delay has run out
  p_delay_gate_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (dly_run && !dly_done) |=> (state_q == ST_WAIT || state_q == ST_IDLE));

  // R2: the parked state never starts a rail
  p_park_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PARK) |-> (!go_pos && !go_neg));

  // R3: the second rail waits for the first rail's flag
  p_second_wait_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FIRST && !first_near && !halt) |=> state_q == ST_FIRST);

  // R6: a halt always lands in the idle state
  p_halt_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> state_q == ST_IDLE);

endmodule

// File: rtl/pwrseq_top.sv
module pwrseq_top #(
  parameter int DELAY_CYC = 16,
  parameter int RAMP_W    = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              sw_off,
  input  logic [1:0]        seq_code,
  input  logic [1:0]        ramp_code,
  input  logic              near_pos,
  input  logic              near_neg,
  input  logic              pd_opt,
  output logic [RAMP_W-1:0] ramp_pos,
  output logic [RAMP_W-1:0] ramp_neg,
  output logic              sw_pos_en,
  output logic              sw_neg_en,
  output logic              disc_drive,
  output logic              disc_full,
  output logic              pd_dis_en
);
  import pwrseq_pkg::*;

  localparam int NRAIL = 2;

  logic                halt;
  logic                dly_run;
  logic                dly_done;
  logic                go_pos;
  logic                go_neg;
  seq_state_e          state;
  logic [NRAIL-1:0]    rail_go;
  logic [RAMP_W-1:0]   rail_ramp [NRAIL];

  assign halt = sw_off || !en;

  pwrseq_delay #(.DELAY_CYC(DELAY_CYC)) u_delay (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (dly_run),
    .done  (dly_done)
  );

  pwrseq_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .halt     (halt),
    .seq_code (seq_code),
    .near_pos (near_pos),
    .near_neg (near_neg),
    .dly_done (dly_done),
    .state    (state),
    .dly_run  (dly_run),
    .go_pos   (go_pos),
    .go_neg   (go_neg)
  );

  // index 0 = positive rail, index 1 = negative rail
  assign rail_go = {go_neg, go_pos};

  for (genvar g = 0; g < NRAIL; g++) begin : g_rail
    pwrseq_ramp #(.RAMP_W(RAMP_W)) u_ramp (
      .clk   (clk),
      .rst_n (rst_n),
      .go    (rail_go[g]),
      .code  (ramp_code),
      .ramp  (rail_ramp[g])
    );
  end

  assign ramp_pos   = rail_ramp[0];
  assign ramp_neg   = rail_ramp[1];
  assign sw_pos_en  = go_pos;
  assign sw_neg_en  = go_neg;
  assign disc_drive = go_pos;
  assign disc_full  = go_pos && near_pos;
  assign pd_dis_en  = !en && pd_opt && (seq_code == SEQ_BOTH);

  // R6: halted cycles show dead outputs at the ports
  p_halt_outputs_r6: assert property (@(posedge clk) disable iff (!rst_n)
    halt |-> (!sw_pos_en && !sw_neg_en && ramp_pos == '0 && ramp_neg == '0 && !disc_drive));

  // R8: full turn-on only while the disconnect is driven
  p_disc_order_r8: assert property (@(posedge clk) disable iff (!rst_n)
    disc_full |-> disc_drive);

  // R7: leaving idle always passes through the delay
  p_restart_delay_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && !halt) |=> state == ST_WAIT);

endmodule

// File: tb/pwrseq_top_bench.sv
`timescale 1ns/1ps
module pwrseq_top_bench;
  localparam int D  = 16;
  localparam int W  = 10;
  localparam int WATCH_CYC = 20000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, sw_off = 1'b0, near_pos = 1'b0, near_neg = 1'b0, pd_opt = 1'b0;
  logic [1:0] seq_code = 2'b00, ramp_code = 2'b00;
  logic [W-1:0] ramp_pos, ramp_neg;
  logic sw_pos_en, sw_neg_en, disc_drive, disc_full, pd_dis_en;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pwrseq_top #(.DELAY_CYC(D), .RAMP_W(W)) u_pwrseq_top (
    .clk(clk), .rst_n(rst_n), .en(en), .sw_off(sw_off),
    .seq_code(seq_code), .ramp_code(ramp_code),
    .near_pos(near_pos), .near_neg(near_neg), .pd_opt(pd_opt),
    .ramp_pos(ramp_pos), .ramp_neg(ramp_neg),
    .sw_pos_en(sw_pos_en), .sw_neg_en(sw_neg_en),
    .disc_drive(disc_drive), .disc_full(disc_full), .pd_dis_en(pd_dis_en)
  );

  // row: seq[33:32] code[31:30] edges[29:22] pos[21:12] neg[11:2] swp[1] swn[0]
  // Expected values were worked out for D=16, W=10.
  localparam int NV = 7;
  localparam logic [33:0] VEC [NV] = '{
    {2'b01, 2'd0, 8'd30,  10'd0,    10'd13,   1'b0, 1'b1},
    {2'b10, 2'd1, 8'd30,  10'd26,   10'd0,    1'b1, 1'b0},
    {2'b11, 2'd2, 8'd27,  10'd40,   10'd40,   1'b1, 1'b1},
    {2'b00, 2'd3, 8'd40,  10'd0,    10'd0,    1'b0, 1'b0},
    {2'b11, 2'd3, 8'd200, 10'd1023, 10'd1023, 1'b1, 1'b1},
    {2'b01, 2'd3, 8'd17,  10'd0,    10'd0,    1'b0, 1'b1},
    {2'b10, 2'd0, 8'd16,  10'd0,    10'd0,    1'b0, 1'b0}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic halt_idle();
    en = 1'b0; sw_off = 1'b0; near_pos = 1'b0; near_neg = 1'b0;
    edges(2);
  endtask

  initial begin
    #(WATCH_CYC * 4);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    edges(3);
    rst_n = 1'b1;
    edges(1);
    // R10: reset state
    chk("R10 ramp_pos", ramp_pos, 0);
    chk("R10 ramp_neg", ramp_neg, 0);
    chk("R10 sw", {sw_pos_en, sw_neg_en, disc_drive, disc_full}, 0);

    // Table: R1 R2 R4 R5
    for (int i = 0; i < NV; i++) begin
      halt_idle();
      seq_code  = VEC[i][33:32];
      ramp_code = VEC[i][31:30];
      en = 1'b1;
      edges(int'(VEC[i][29:22]));
      chk($sformatf("R2/R4/R5 row%0d ramp_pos", i), ramp_pos, int'(VEC[i][21:12]));
      chk($sformatf("R2/R4/R5 row%0d ramp_neg", i), ramp_neg, int'(VEC[i][11:2]));
      chk($sformatf("R1/R2 row%0d sw_pos_en", i), sw_pos_en, int'(VEC[i][1]));
      chk($sformatf("R1/R2 row%0d sw_neg_en", i), sw_neg_en, int'(VEC[i][0]));
    end

    // R3: negative first, step 2
    halt_idle();
    seq_code = 2'b01; ramp_code = 2'd1; en = 1'b1;
    edges(20);
    chk("R3 neg ramp before flag", ramp_neg, 6);
    near_pos = 1'b1;                 // second rail's own flag: ignored
    edges(3);
    chk("R3 pos held off by own flag", sw_pos_en, 0);
    chk("R8 disc_full off while pos off", disc_full, 0);
    near_pos = 1'b0;
    near_neg = 1'b1;
    edges(1);
    chk("R3 pos switch on after flag", sw_pos_en, 1);
    chk("R3 pos ramp zero first cycle", ramp_pos, 0);
    edges(1);
    chk("R4 pos ramp first step", ramp_pos, 2);
    // R8
    chk("R8 disc_drive", disc_drive, 1);
    chk("R8 disc_full before flag", disc_full, 0);
    near_pos = 1'b1;
    edges(1);
    chk("R8 disc_full after flag", disc_full, 1);

    // R6: switches-off
    sw_off = 1'b1;
    edges(1);
    chk("R6 sw off", {sw_pos_en, sw_neg_en, disc_drive, disc_full}, 0);
    chk("R6 ramp_pos", ramp_pos, 0);
    chk("R6 ramp_neg", ramp_neg, 0);
    // R7: restart from full delay (seq 01, neg first, flags cleared)
    near_pos = 1'b0; near_neg = 1'b0;
    sw_off = 1'b0;
    edges(D);
    chk("R7 still in delay", sw_neg_en, 0);
    edges(1);
    chk("R7 neg on after delay", sw_neg_en, 1);
    chk("R7 neg ramp restarts at zero", ramp_neg, 0);
    edges(1);
    chk("R7 neg first step", ramp_neg, 2);
    // R6: enable low
    en = 1'b0;
    edges(1);
    chk("R6 en low outputs", {sw_pos_en, sw_neg_en, disc_drive}, 0);
    chk("R6 en low ramp", ramp_neg, 0);

    // R9
    pd_opt = 1'b1; seq_code = 2'b11;
    edges(1);
    chk("R9 discharge on", pd_dis_en, 1);
    seq_code = 2'b10;
    edges(1);
    chk("R9 wrong code", pd_dis_en, 0);
    seq_code = 2'b11; en = 1'b1;
    edges(1);
    chk("R9 enabled", pd_dis_en, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule